// File: doc/BRIEF.md
# Light-Level Window Alarm with Run-Length Qualification

This block sits beside a light-sensor converter and watches each result the converter produces. It checks every result against a programmable upper limit and a programmable lower limit. A result strictly above the upper limit is out of window, and so is a result strictly below the lower limit. A result equal to either limit counts as inside the window. An alarm flag is raised only after a selectable number of out-of-window results has arrived in an unbroken run. This lets short spikes, such as a camera flash, pass without an alarm.

The alarm output is active low and open drain. The block presents it as a pull-down enable: when the enable is high the pad drives low, and otherwise the pad is released. Once raised, the flag stays set until a clear strobe arrives. Raising the flag never holds off the converter, so results keep arriving and keep being evaluated.

Top module: `lux_window_alarm`

## Requirements
- R1: While reset is high and on the first cycle after it, `alarm_flag` and `alarm_pull_low` are 0.
- R2: A valid result counts as out of window when `res_data > lim_hi` or `res_data < lim_lo`, using unsigned compare. A result equal to `lim_hi` or `lim_lo` is in window.
- R3: `run_sel` sets the run length needed to raise the alarm: 2'b00 needs 1, 2'b01 needs 4, 2'b10 needs 8 and 2'b11 needs 16 consecutive out-of-window results.
- R4: Any valid in-window result resets the run count to zero, so the next alarm needs a full new run.
- R5: Once set, `alarm_flag` stays set through any later results, in window or not, until `alarm_clr` is sampled high.
- R6: If `alarm_clr` is high in the same cycle as a result that completes a run, the flag is set or stays set.
- R7: `alarm_pull_low` equals `alarm_flag` in every cycle. A value of 1 means drive the pad low and 0 means release it.
- R8: Cycles with `res_valid` low change neither the run count nor the flag, apart from a clear. Out-of-window results separated by idle cycles still form one run.
- R9: The flag rises on the same clock edge that samples the result completing the run, and on no other edge.
- R10: The run count saturates at the selected length. After a clear, while the run is unbroken, the very next out-of-window result raises the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Strobe marking a new conversion result |
| res_data | input | DATA_W | Conversion result, unsigned |
| lim_hi | input | DATA_W | Upper window limit |
| lim_lo | input | DATA_W | Lower window limit |
| run_sel | input | 2 | Selects the required run length |
| alarm_clr | input | 1 | Strobe that clears the alarm flag |
| alarm_flag | output | 1 | Alarm flag, sticky |
| alarm_pull_low | output | 1 | Open-drain enable: 1 drives the pad low, 0 releases it |

## Verification
The bench builds the block with DATA_W set to 6. With that width, every possible result value can be applied for each of a grid of limit pairs, including equal limits and limits at 0 and 63, so the window compare is covered exhaustively at both edges. The run-length logic is independent of data width and stays at full size. All four run lengths are therefore exercised, including the 16-result run, with idle gaps inside runs, breaks one short of a full run, clears that collide with triggers, and re-triggering from a saturated run.

// File: rtl/lux_alarm_pkg.sv
package lux_alarm_pkg;

    localparam int MAX_RUN = 16;
    localparam int RUN_W   = $clog2(MAX_RUN + 1);

    typedef enum logic [1:0] {
        RUN_1  = 2'b00,
        RUN_4  = 2'b01,
        RUN_8  = 2'b10,
        RUN_16 = 2'b11
    } run_sel_e;

    typedef struct packed {
        logic above;
        logic below;
    } win_cmp_t;

    function automatic logic [RUN_W-1:0] run_length(input run_sel_e sel);
        case (sel)
            RUN_1:   return RUN_W'(1);
            RUN_4:   return RUN_W'(4);
            RUN_8:   return RUN_W'(8);
            default: return RUN_W'(MAX_RUN);
        endcase
    endfunction

    function automatic logic is_outside(input win_cmp_t c);
        return c.above | c.below;
    endfunction

endpackage

// File: rtl/lux_win_compare.sv
module lux_win_compare
    import lux_alarm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] upper,
    input  logic [DATA_W-1:0] lower,
    output win_cmp_t          cmp
);
    always_comb begin
        cmp.above = (value > upper);
        cmp.below = (value < lower);
    end
endmodule

// File: rtl/lux_run_counter.sv
module lux_run_counter
    import lux_alarm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sample,
    input  logic             outside,
    input  logic [RUN_W-1:0] need,
    output logic             fire
);
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_inc;
    logic             reached;

    always_comb begin
        run_inc = run_q + RUN_W'(1);
        reached = (run_inc >= need);
        fire    = sample & outside & reached;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (sample) begin
            if (!outside)
                run_q <= '0;
            else if (reached)
                run_q <= need;
            else
                run_q <= run_inc;
        end
    end
endmodule

// File: rtl/lux_alarm_latch.sv
module lux_alarm_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic flag,
    output logic pull_low
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set_req)
            flag_q <= 1'b1;
        else if (clr_req)
            flag_q <= 1'b0;
    end

    assign flag     = flag_q;
    assign pull_low = flag_q;
endmodule

// File: rtl/lux_window_alarm.sv
module lux_window_alarm
    import lux_alarm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [DATA_W-1:0] lim_hi,
    input  logic [DATA_W-1:0] lim_lo,
    input  logic [1:0]        run_sel,
    input  logic              alarm_clr,
    output logic              alarm_flag,
    output logic              alarm_pull_low
);
    win_cmp_t         cmp;
    logic [RUN_W-1:0] need;
    logic             fire;

    assign need = run_length(run_sel_e'(run_sel));

    lux_win_compare #(.DATA_W(DATA_W)) u_cmp (
        .value (res_data),
        .upper (lim_hi),
        .lower (lim_lo),
        .cmp   (cmp)
    );

    lux_run_counter u_run (
        .clk     (clk),
        .rst     (rst),
        .sample  (res_valid),
        .outside (is_outside(cmp)),
        .need    (need),
        .fire    (fire)
    );

    lux_alarm_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .set_req  (fire),
        .clr_req  (alarm_clr),
        .flag     (alarm_flag),
        .pull_low (alarm_pull_low)
    );
endmodule

// File: rtl/lux_alarm_checker.sv
module lux_alarm_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic [DATA_W-1:0] lim_hi,
    input logic [DATA_W-1:0] lim_lo,
    input logic [1:0]        run_sel,
    input logic              alarm_clr,
    input logic              alarm_flag,
    input logic              alarm_pull_low
);
    logic outside;
    assign outside = (res_data > lim_hi) || (res_data < lim_lo);

    assert_single_run_sets_R3: assert property (@(posedge clk) disable iff (rst)
        (res_valid && outside && run_sel == 2'b00) |=> alarm_flag);

    assert_sticky_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !alarm_clr) |=> alarm_flag);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!res_valid && !alarm_clr) |=> $stable(alarm_flag));

    assert_rise_needs_result_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_flag) |-> $past(res_valid && outside));

    assert_inside_no_set_R2: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !outside && !alarm_flag) |=> !alarm_flag);

    assert_clr_drops_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(alarm_flag) |-> $past(alarm_clr));

    assert_pin_follows_R7: assert property (@(posedge clk) disable iff (rst)
        alarm_pull_low == alarm_flag);
endmodule

bind lux_window_alarm lux_alarm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .res_valid      (res_valid),
    .res_data       (res_data),
    .lim_hi         (lim_hi),
    .lim_lo         (lim_lo),
    .run_sel        (run_sel),
    .alarm_clr      (alarm_clr),
    .alarm_flag     (alarm_flag),
    .alarm_pull_low (alarm_pull_low)
);

// File: tb/test_lux_window_alarm.sv
module test_lux_window_alarm;
    localparam int  DW       = 6;
    localparam time CLK_T    = 10;
    localparam int  WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst;
    logic          res_valid;
    logic [DW-1:0] res_data;
    logic [DW-1:0] lim_hi;
    logic [DW-1:0] lim_lo;
    logic [1:0]    run_sel;
    logic          alarm_clr;
    logic          alarm_flag;
    logic          alarm_pull_low;

    int compared = 0;
    int mismatched = 0;
    int m_run = 0;
    bit m_flag = 0;
    bit finished = 0;

    always #(CLK_T/2) clk = ~clk;

    lux_window_alarm #(.DATA_W(DW)) i_lux_window_alarm (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .run_sel(run_sel),
        .alarm_clr(alarm_clr), .alarm_flag(alarm_flag),
        .alarm_pull_low(alarm_pull_low)
    );

    function automatic int need_of(input logic [1:0] s);
        case (s)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 16;
        endcase
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // One clock with given inputs; the reference model is advanced and the
    // outputs are compared one time unit after the edge.
    task automatic step(input logic v, input logic [DW-1:0] d, input logic c,
                        input string req);
        bit outside;
        bit trig;
        int need;
        res_valid = v; res_data = d; alarm_clr = c;
        @(posedge clk);
        #1;
        need = need_of(run_sel);
        trig = 0;
        if (v) begin
            outside = (d > lim_hi) || (d < lim_lo);
            if (outside) begin
                m_run = (m_run + 1 >= need) ? need : m_run + 1;
                trig  = (m_run >= need);
            end else begin
                m_run = 0;
            end
        end
        if (trig) m_flag = 1;
        else if (c) m_flag = 0;
        check(req, alarm_flag, m_flag);
        check("R7", alarm_pull_low, m_flag);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : stim
        rst = 1; res_valid = 0; res_data = '0; alarm_clr = 0;
        lim_hi = 6'd40; lim_lo = 6'd20; run_sel = 2'b00;
        repeat (3) @(posedge clk);
        #1;
        check("R1", alarm_flag, 1'b0);
        check("R1", alarm_pull_low, 1'b0);
        rst = 0;
        m_run = 0; m_flag = 0;
        step(0, '0, 0, "R1");

        // R2: exhaustive data sweep over a grid of limit pairs, run length 1
        run_sel = 2'b00;
        for (int lo = 0; lo < 64; lo += 9) begin
            for (int hi = lo; hi < 64; hi += 13) begin
                lim_lo = DW'(lo); lim_hi = DW'(hi);
                for (int d = 0; d < 64; d++) begin
                    step(1, DW'(d), 0, "R2");
                    step(0, '0, 1, "R2");
                end
            end
        end
        lim_lo = 6'd0; lim_hi = 6'd63;
        for (int d = 0; d < 64; d++) step(1, DW'(d), 0, "R2");

        // R3/R4/R8/R9 for each run length
        lim_lo = 6'd20; lim_hi = 6'd40;
        for (int s = 0; s < 4; s++) begin
            run_sel = 2'(s);
            step(1, 6'd30, 1, "R4");
            for (int k = 0; k < need_of(2'(s)) - 1; k++) step(1, 6'd50, 0, "R3");
            step(1, 6'd40, 0, "R4");
            for (int k = 0; k < need_of(2'(s)) - 1; k++) begin
                step(1, 6'd5, 0, "R3");
                step(0, 6'd30, 0, "R8");
            end
            step(1, 6'd63, 0, "R9");
            step(0, '0, 0, "R8");
            // R5: returning into the window keeps the flag
            for (int k = 0; k < 5; k++) step(1, 6'd25, 0, "R5");
            step(1, 6'd20, 1, "R5");
        end

        // R6: clear collides with a completing result
        run_sel = 2'b01;
        step(1, 6'd30, 1, "R6");
        for (int k = 0; k < 3; k++) step(1, 6'd50, 0, "R6");
        step(1, 6'd50, 1, "R6");
        step(0, '0, 0, "R6");

        // R10: saturated run retriggers right after a clear
        step(0, '0, 1, "R10");
        step(1, 6'd55, 0, "R10");
        step(0, '0, 1, "R10");
        run_sel = 2'b00;
        step(1, 6'd1, 0, "R10");
        run_sel = 2'b11;
        step(0, '0, 1, "R10");
        step(1, 6'd1, 0, "R10");

        // R1: reset in the middle of an alarm
        rst = 1;
        @(posedge clk); #1;
        check("R1", alarm_flag, 1'b0);
        rst = 0;
        m_run = 0; m_flag = 0;
        step(0, '0, 0, "R1");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule